// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This block forms the effective memory address for one load or store per cycle in a load/store pipeline stage. Each request carries a three-bit mode code, a base operand, an index operand, a two-bit scale selector, a raw immediate with a width selector, and the current program counter. The unit produces the address and, for the two modes that modify the base register as a side effect, the value to write back into that register together with a write enable.

Six modes are supported: base plus offset, base plus index, base plus shifted index plus offset, post-increment, offset with base update, and program-counter relative. A mode that needs a second memory read to find the final address is rejected and flagged, as is the one spare code. Every sum wraps modulo the address width. All outputs are registered, and a result appears one clock after its request.

Top module: `addr_gen_unit`

## Requirements
- R1: Mode code 0 (offset) gives address = base + extended immediate, with wb_en low.
- R2: Mode code 1 (base plus index) gives address = base + index; the immediate has no effect and wb_en is low.
- R3: Mode code 2 (scaled) gives address = base + (index shifted left by scale_sel) + extended immediate, where scale_sel 0, 1, 2, 3 multiplies the index by 1, 2, 4, 8; wb_en is low.
- R4: Mode code 3 (post-increment) gives address = unmodified base, wb_val = base + 1 and wb_en high.
- R5: Mode code 4 (offset with update) gives address = base + extended immediate, wb_val equal to that same address, and wb_en high.
- R6: Mode code 5 (PC-relative) gives address = pc + extended immediate, with wb_en low.
- R7: The immediate is sign-extended from bit 7 when imm_width is 0, from bit 15 when it is 1, and taken as all 32 bits when it is 2 or 3; bits above the selected width have no effect.
- R8: Mode codes 6 (indirect through memory) and 7 (spare) raise bad_mode, keep wb_en low and give address 0.
- R9: out_valid is high exactly one cycle after in_valid is high; a cycle without in_valid leaves out_valid, wb_en and bad_mode low in the next cycle.
- R10: All address and writeback sums wrap modulo 2^AW.
- R11: While rst is high at a clock edge, out_valid, wb_en, bad_mode, addr and wb_val are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| base_val | input | AW | Base register operand |
| index_val | input | AW | Index register operand |
| scale_sel | input | 2 | Index shift amount (0..3) |
| imm_raw | input | 32 | Raw immediate field |
| imm_width | input | 2 | Immediate width select (8/16/32 bits) |
| pc_val | input | AW | Program counter of the request |
| out_valid | output | 1 | Result present this cycle |
| addr | output | AW | Effective address |
| wb_val | output | AW | Base register writeback value |
| wb_en | output | 1 | Base register writeback enable |
| bad_mode | output | 1 | Request used an unsupported mode |

## Verification
The address and the base writeback are produced in the same result cycle for the two updating modes, and the post-increment case in particular carries two different sums. Both are provoked with bases close to the top of the address range so that the address and the writeback wrap differently, and with back-to-back requests so that a writeback result is followed at once by a non-updating or rejected one. A scoreboard compares address, writeback value, enable and the illegal flag together for every result, so a writeback leaking into a neighbouring request or a wrong operand for one of the two sums is reported.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_OFFSET   = 3'd0,
    AM_BASE_IDX = 3'd1,
    AM_SCALED   = 3'd2,
    AM_POST_INC = 3'd3,
    AM_PRE_UPD  = 3'd4,
    AM_PC_REL   = 3'd5,
    AM_MEM_IND  = 3'd6,
    AM_SPARE    = 3'd7
  } am_mode_e;

  typedef enum logic [1:0] {
    IW_BYTE  = 2'd0,
    IW_HALF  = 2'd1,
    IW_WORD  = 2'd2,
    IW_WORD2 = 2'd3
  } imm_width_e;

  localparam int unsigned IMM_FIELD_W = 32;
  localparam int unsigned SCALE_SEL_W = 2;

  function automatic logic mode_writes_base(input logic [2:0] m);
    return (m == 3'(AM_POST_INC)) || (m == 3'(AM_PRE_UPD));
  endfunction

endpackage

// File: rtl/agu_imm_ext.sv
module agu_imm_ext
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [IMM_FIELD_W-1:0] imm_raw,
  input  logic [1:0]             imm_width,
  output logic [AW-1:0]          imm_sx
);

  logic signed [7:0]  imm_b;
  logic signed [15:0] imm_h;
  logic signed [31:0] imm_w;

  assign imm_b = imm_raw[7:0];
  assign imm_h = imm_raw[15:0];
  assign imm_w = imm_raw[31:0];

  always_comb begin
    case (imm_width_e'(imm_width))
      IW_BYTE:  imm_sx = AW'(imm_b);
      IW_HALF:  imm_sx = AW'(imm_h);
      default:  imm_sx = AW'(imm_w);
    endcase
  end

endmodule

// File: rtl/agu_index_scaler.sv
module agu_index_scaler
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]          index_val,
  input  logic [SCALE_SEL_W-1:0] scale_sel,
  output logic [AW-1:0]          index_sc
);

  localparam int unsigned NSCALE = 1 << SCALE_SEL_W;

  logic [AW-1:0] shifted [NSCALE];

  for (genvar g = 0; g < NSCALE; g++) begin : g_shift
    assign shifted[g] = index_val << g;
  end

  assign index_sc = shifted[scale_sel];

endmodule

// File: rtl/agu_mode_calc.sv
module agu_mode_calc
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] index_sc,
  input  logic [AW-1:0] imm_sx,
  input  logic [AW-1:0] pc_val,
  output logic [AW-1:0] ea_nxt,
  output logic [AW-1:0] wb_nxt,
  output logic          wb_req,
  output logic          illegal
);

  logic [AW-1:0] base_imm;

  assign base_imm = base_val + imm_sx;

  always_comb begin
    ea_nxt  = '0;
    wb_nxt  = '0;
    wb_req  = 1'b0;
    illegal = 1'b0;
    case (am_mode_e'(mode))
      AM_OFFSET:   ea_nxt = base_imm;
      AM_BASE_IDX: ea_nxt = base_val + index_val;
      AM_SCALED:   ea_nxt = base_imm + index_sc;
      AM_POST_INC: begin
        ea_nxt = base_val;
        wb_nxt = base_val + AW'(1);
        wb_req = 1'b1;
      end
      AM_PRE_UPD: begin
        ea_nxt = base_imm;
        wb_nxt = base_imm;
        wb_req = 1'b1;
      end
      AM_PC_REL:   ea_nxt = pc_val + imm_sx;
      default:     illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [2:0]             mode,
  input  logic [AW-1:0]          base_val,
  input  logic [AW-1:0]          index_val,
  input  logic [SCALE_SEL_W-1:0] scale_sel,
  input  logic [IMM_FIELD_W-1:0] imm_raw,
  input  logic [1:0]             imm_width,
  input  logic [AW-1:0]          pc_val,
  output logic                   out_valid,
  output logic [AW-1:0]          addr,
  output logic [AW-1:0]          wb_val,
  output logic                   wb_en,
  output logic                   bad_mode
);

  logic [AW-1:0] imm_sx;
  logic [AW-1:0] index_sc;
  logic [AW-1:0] ea_nxt;
  logic [AW-1:0] wb_nxt;
  logic          wb_req;
  logic          illegal;

  agu_imm_ext #(.AW(AW)) u_imm (
    .imm_raw   (imm_raw),
    .imm_width (imm_width),
    .imm_sx    (imm_sx)
  );

  agu_index_scaler #(.AW(AW)) u_scale (
    .index_val (index_val),
    .scale_sel (scale_sel),
    .index_sc  (index_sc)
  );

  agu_mode_calc #(.AW(AW)) u_calc (
    .mode      (mode),
    .base_val  (base_val),
    .index_val (index_val),
    .index_sc  (index_sc),
    .imm_sx    (imm_sx),
    .pc_val    (pc_val),
    .ea_nxt    (ea_nxt),
    .wb_nxt    (wb_nxt),
    .wb_req    (wb_req),
    .illegal   (illegal)
  );

  // Result register: one cycle from request to result.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      addr      <= '0;
      wb_val    <= '0;
      wb_en     <= 1'b0;
      bad_mode  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & wb_req & ~illegal;
      bad_mode  <= in_valid & illegal;
      if (in_valid) begin
        addr   <= ea_nxt;
        wb_val <= wb_nxt;
      end
    end
  end

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wb_en && !bad_mode));

  p_illegal_nowb_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 3'(AM_MEM_IND) || mode == 3'(AM_SPARE)))
      |=> (bad_mode && !wb_en && addr == '0));

  p_postinc_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'(AM_POST_INC))
      |=> (wb_en && addr == $past(base_val) && wb_val == $past(base_val) + AW'(1)));

  p_preupd_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'(AM_PRE_UPD)) |=> (wb_en && wb_val == addr));

  p_offset_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'(AM_OFFSET))
      |=> (!wb_en && addr == $past(base_val) + $past(imm_sx)));

  p_pcrel_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'(AM_PC_REL))
      |=> (!wb_en && addr == $past(pc_val) + $past(imm_sx)));

  p_wb_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (out_valid && !bad_mode));

endmodule

// File: tb/sim_addr_gen_unit.sv
`timescale 1ns/1ps
module sim_addr_gen_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base_val = '0;
  logic [31:0] index_val = '0;
  logic [1:0]  scale_sel = '0;
  logic [31:0] imm_raw = '0;
  logic [1:0]  imm_width = '0;
  logic [31:0] pc_val = '0;
  logic        out_valid;
  logic [31:0] addr;
  logic [31:0] wb_val;
  logic        wb_en;
  logic        bad_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] ea;
    logic [31:0] wbv;
    logic        wbe;
    logic        bad;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  addr_gen_unit #(.AW(32)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .base_val(base_val), .index_val(index_val), .scale_sel(scale_sel),
    .imm_raw(imm_raw), .imm_width(imm_width), .pc_val(pc_val),
    .out_valid(out_valid), .addr(addr), .wb_val(wb_val),
    .wb_en(wb_en), .bad_mode(bad_mode)
  );

  function automatic logic [31:0] sx(input logic [31:0] im, input logic [1:0] w);
    case (w)
      2'd0:    return {{24{im[7]}}, im[7:0]};
      2'd1:    return {{16{im[15]}}, im[15:0]};
      default: return im;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] m, input logic [31:0] b, input logic [31:0] ix,
                      input logic [1:0] sc, input logic [31:0] im, input logic [1:0] w,
                      input logic [31:0] pc, input string tag);
    exp_t e;
    logic [31:0] s;
    @(negedge clk);
    mode = m; base_val = b; index_val = ix; scale_sel = sc;
    imm_raw = im; imm_width = w; pc_val = pc; in_valid = 1'b1;
    s = sx(im, w);
    e.ea = 32'h0; e.wbv = 32'h0; e.wbe = 1'b0; e.bad = 1'b0; e.tag = tag;
    case (m)
      3'd0: e.ea = b + s;
      3'd1: e.ea = b + ix;
      3'd2: e.ea = b + (ix * (32'd1 << sc)) + s;
      3'd3: begin e.ea = b; e.wbv = b + 32'd1; e.wbe = 1'b1; end
      3'd4: begin e.ea = b + s; e.wbv = b + s; e.wbe = 1'b1; end
      3'd5: e.ea = pc + s;
      default: e.bad = 1'b1;
    endcase
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compare every result against the scoreboard head.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9 unexpected result", 32'(out_valid), 32'h0);
        end else begin
          exp_t e;
          bit ok;
          e = sb.pop_front();
          ok = (addr == e.ea) && (wb_en == e.wbe) && (bad_mode == e.bad) &&
               (!e.wbe || wb_val == e.wbv);
          if (!ok)
            $display("FAIL %s: actual ea=%h wb=%b/%h bad=%b expected ea=%h wb=%b/%h bad=%b",
                     e.tag, addr, wb_en, wb_val, bad_mode, e.ea, e.wbe, e.wbv, e.bad);
          n_cmp++;
          if (!ok) n_bad++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(out_valid == 1'b0 && wb_en == 1'b0 && bad_mode == 1'b0, "R11 flags in reset",
        {29'd0, out_valid, wb_en, bad_mode}, 32'h0);
    chk(addr == 32'h0 && wb_val == 32'h0, "R11 data in reset", addr | wb_val, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    send(3'd0, 32'h0000_1000, 32'h0, 2'd0, 32'h0000_0010, 2'd2, 32'h0, "R1 offset positive");
    send(3'd0, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_FFF0, 2'd2, 32'h0, "R1 offset negative");
    send(3'd1, 32'h0000_2000, 32'h0000_0345, 2'd3, 32'h7777_7777, 2'd2, 32'h0, "R2 immediate ignored");
    for (int k = 0; k < 4; k++)
      send(3'd2, 32'h0001_0000, 32'h0000_0013, 2'(k), 32'h0000_0004, 2'd0, 32'h0, "R3 scaled index");
    send(3'd2, 32'h8000_0000, 32'hC000_0001, 2'd3, 32'h0000_00FF, 2'd0, 32'h0, "R3 R10 scaled wrap");
    send(3'd3, 32'h0000_4000, 32'h0, 2'd0, 32'h0000_0055, 2'd2, 32'h0, "R4 post-increment");
    send(3'd3, 32'hFFFF_FFFF, 32'h0, 2'd0, 32'h0, 2'd2, 32'h0, "R4 R10 post-increment wrap");
    send(3'd4, 32'hFFFF_FFF8, 32'h0, 2'd0, 32'h0000_0010, 2'd0, 32'h0, "R5 R10 update wrap");
    send(3'd1, 32'h0000_0100, 32'h0000_0001, 2'd0, 32'h0, 2'd2, 32'h0, "R2 after update");
    send(3'd5, 32'h1234_5678, 32'h0, 2'd0, 32'h0000_8000, 2'd1, 32'h0040_0000, "R6 R7 pc-rel half negative");
    send(3'd5, 32'h0, 32'h0, 2'd0, 32'hABCD_0123, 2'd0, 32'h0000_0100, "R7 byte upper bits ignored");
    send(3'd0, 32'h0000_0000, 32'h0, 2'd0, 32'h5555_80FF, 2'd0, 32'h0, "R7 byte sign");
    send(3'd0, 32'h0000_0000, 32'h0, 2'd0, 32'h8001_7FFF, 2'd1, 32'h0, "R7 half positive");
    send(3'd0, 32'h0000_0010, 32'h0, 2'd0, 32'h8000_0000, 2'd3, 32'h0, "R7 word code 3");
    send(3'd6, 32'h0000_4000, 32'h1, 2'd1, 32'h4, 2'd2, 32'h0, "R8 memory-indirect rejected");
    send(3'd4, 32'h0000_0200, 32'h0, 2'd0, 32'h0000_0008, 2'd0, 32'h0, "R5 update after reject");
    send(3'd7, 32'h0000_4000, 32'h1, 2'd1, 32'h4, 2'd2, 32'h0, "R8 spare code rejected");
    idle(1);
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0 && wb_en == 1'b0 && bad_mode == 1'b0, "R9 idle cycle quiet",
        {29'd0, out_valid, wb_en, bad_mode}, 32'h0);
    send(3'd3, 32'h0000_0010, 32'h0, 2'd0, 32'h0, 2'd0, 32'h0, "R9 restart after idle");
    idle(3);
    repeat (2) @(posedge clk);
    #1;
    chk(sb.size() == 0, "R9 every request answered", 32'(sb.size()), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule